// File: doc/BRIEF.md
# Shared-Line Serial Clock Synchronizer

This block produces the serial clock for a two-wire bus master whose clock line is shared with other masters and with slaves. The line is open-drain and wired-AND: any device can hold it low, and it rises only after every device has let go. The block never drives the line high. It either enables its pull-down or releases the line. It watches the real line level through a synchronizer and times its own phases from what it sees there.

A low phase is counted from a programmed length. The block then releases the line and waits until the line is actually seen high. Only after that does it count a programmed high phase and then pull low again. As a result, the longest low period among the masters sets the bus timing, and so does any slave that holds the clock low as a flow-control handshake. If another device pulls the line low during the high count, the high phase ends at once and a new low phase starts. A rising strobe marks the start of each counted high phase, so a data shifter can sample on it. A falling strobe marks the start of each low phase the block drives.

Top module: `scl_clock_sync`

## Requirements
- R1: While reset is asserted, and afterwards until enabled, the pull-down output, the wait output and both strobes are 0.
- R2: Each low phase the block starts keeps the pull-down asserted for max(lowCount,1) clock cycles. A count of zero behaves as one.
- R3: With no other device pulling, the line stays high for highCount+3 cycles, where a count of zero behaves as one. The 3 cycles are the two-flop synchronizer plus edge detection.
- R4: When another master holds the line low longer than lowCount, the line's low time equals that longer low time. The block does not start its high count before the line rises.
- R5: waitHigh is 1 from the cycle the block releases the line until the synchronized rise is seen, which is busLow - max(lowCount,1) + 3 cycles. It is never 1 while the pull-down is asserted.
- R6: A slave that holds the line low for longer than the block's low phase stretches that one period. The block's following high phase is still highCount+3 cycles.
- R7: A falling edge of the line during the high count ends the high phase. The pull-down asserts 3 cycles after the line falls and is then held for a full low phase.
- R8: riseStrobe is a one-cycle pulse in the 4th cycle of each line-high run that leads to a counted high phase. The pull-down and waitHigh are both 0 in that cycle.
- R9: fallStrobe is a one-cycle pulse in the first cycle of each low phase the block drives, coincident with the pull-down.
- R10: One cycle after stopReq is 1 or enable is 0, the pull-down and waitHigh are 0. They stay 0 while that condition holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| lowCount | input | CNT_W | Low phase length in cycles (0 acts as 1) |
| highCount | input | CNT_W | High phase length in cycles (0 acts as 1) |
| enable | input | 1 | Run the clock generator |
| stopReq | input | 1 | Return to idle with the line released |
| sclIn | input | 1 | Level of the shared clock line |
| sclPullDown | output | 1 | Open-drain pull-down enable |
| waitHigh | output | 1 | Released and waiting for the line to rise |
| riseStrobe | output | 1 | First cycle of a counted high phase |
| fallStrobe | output | 1 | First cycle of a driven low phase |

## Verification
The bench drives a second master with a longer low time and checks that the bus low time follows that master. A design that started its high count on its own release would instead shorten the low time and report a short wait. A slave stretch lengthens one period, so a block that timed out of the wait, or that ignored the line level, would show a wrong low run and wrong wait length. A third device pulls the line low in the middle of a high count. A block that ignored the falling edge would show a full-length high run and a short following low. Zero counts and a stop during a low phase catch counters that underflow and states that keep the pull-down asserted.

// File: rtl/sclsync_pkg.sv
package sclsync_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOW  = 2'd1,
    ST_WAIT = 2'd2,
    ST_HIGH = 2'd3
  } sclState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadLow;
    logic loadHigh;
  } ctlStrobe_t;
endpackage

// File: rtl/scl_timing_path.sv
module scl_timing_path
  import sclsync_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] lowCount,
  input  logic [CNT_W-1:0] highCount,
  input  ctlStrobe_t       strobe,
  input  logic             sclIn,
  output logic             cntDone,
  output logic             sclRise,
  output logic             sclFall
);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [SYNC_STAGES-1:0] syncChain;
  logic                   sclPrev;
  logic                   sclLevel;
  logic [CNT_W-1:0]       phaseCnt;

  // line idles high, so the chain resets to 1
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncChain <= '1;
      sclPrev   <= 1'b1;
    end else begin
      syncChain <= {syncChain[SYNC_STAGES-2:0], sclIn};
      sclPrev   <= sclLevel;
    end
  end

  assign sclLevel = syncChain[SYNC_STAGES-1];
  assign sclRise  = sclLevel & ~sclPrev;
  assign sclFall  = ~sclLevel & sclPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseCnt <= '0;
    end else if (strobe.loadLow) begin
      phaseCnt <= lowCount;
    end else if (strobe.loadHigh) begin
      phaseCnt <= highCount;
    end else if (phaseCnt != '0) begin
      phaseCnt <= phaseCnt - CNT_ONE;
    end
  end

  // zero and one both finish after a single cycle
  assign cntDone = (phaseCnt <= CNT_ONE);
endmodule

// File: rtl/scl_phase_ctrl.sv
module scl_phase_ctrl
  import sclsync_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       enable,
  input  logic       stopReq,
  input  logic       cntDone,
  input  logic       sclRise,
  input  logic       sclFall,
  output ctlStrobe_t strobe,
  output logic       sclPullDown,
  output logic       waitHigh,
  output logic       riseStrobe,
  output logic       fallStrobe
);
  sclState_t state, nextState;

  always_comb begin
    nextState       = state;
    strobe          = '0;
    unique case (state)
      ST_IDLE: begin
        nextState      = ST_LOW;
        strobe.loadLow = 1'b1;
      end
      ST_LOW:  if (cntDone) nextState = ST_WAIT;
      ST_WAIT: begin
        if (sclRise) begin
          nextState       = ST_HIGH;
          strobe.loadHigh = 1'b1;
        end
      end
      ST_HIGH: begin
        if (sclFall || cntDone) begin
          nextState      = ST_LOW;
          strobe.loadLow = 1'b1;
        end
      end
      default: nextState = ST_IDLE;
    endcase
    if (stopReq || !enable) begin
      nextState = ST_IDLE;
      strobe    = '0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      riseStrobe <= 1'b0;
      fallStrobe <= 1'b0;
    end else begin
      state      <= nextState;
      riseStrobe <= (nextState == ST_HIGH) && (state != ST_HIGH);
      fallStrobe <= (nextState == ST_LOW) && (state != ST_LOW);
    end
  end

  assign sclPullDown = (state == ST_LOW);
  assign waitHigh    = (state == ST_WAIT);
endmodule

// File: rtl/scl_clock_sync.sv
module scl_clock_sync
  import sclsync_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] lowCount,
  input  logic [CNT_W-1:0] highCount,
  input  logic             enable,
  input  logic             stopReq,
  input  logic             sclIn,
  output logic             sclPullDown,
  output logic             waitHigh,
  output logic             riseStrobe,
  output logic             fallStrobe
);
  ctlStrobe_t strobe;
  logic       cntDone;
  logic       sclRise;
  logic       sclFall;

  scl_timing_path #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) uPath (
    .clk       (clk),
    .rstN      (rstN),
    .lowCount  (lowCount),
    .highCount (highCount),
    .strobe    (strobe),
    .sclIn     (sclIn),
    .cntDone   (cntDone),
    .sclRise   (sclRise),
    .sclFall   (sclFall)
  );

  scl_phase_ctrl uCtrl (
    .clk         (clk),
    .rstN        (rstN),
    .enable      (enable),
    .stopReq     (stopReq),
    .cntDone     (cntDone),
    .sclRise     (sclRise),
    .sclFall     (sclFall),
    .strobe      (strobe),
    .sclPullDown (sclPullDown),
    .waitHigh    (waitHigh),
    .riseStrobe  (riseStrobe),
    .fallStrobe  (fallStrobe)
  );
endmodule

// File: rtl/scl_clock_sync_chk.sv
module scl_clock_sync_chk (
  input logic clk,
  input logic rstN,
  input logic enable,
  input logic stopReq,
  input logic sclPullDown,
  input logic waitHigh,
  input logic riseStrobe,
  input logic fallStrobe
);
  // R10
  stop_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stopReq || !enable) |=> (!sclPullDown && !waitHigh));

  // R5
  wait_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({sclPullDown, waitHigh}));

  // R5
  wait_after_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(waitHigh) |-> $past(sclPullDown));

  // R8
  rise_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    riseStrobe |=> !riseStrobe);

  // R8
  rise_released_chk: assert property (@(posedge clk) disable iff (!rstN)
    riseStrobe |-> (!sclPullDown && !waitHigh));

  // R9
  fall_pull_chk: assert property (@(posedge clk) disable iff (!rstN)
    fallStrobe |-> sclPullDown);

  // R9
  fall_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    fallStrobe |=> !fallStrobe);
endmodule

bind scl_clock_sync scl_clock_sync_chk uChk (
  .clk         (clk),
  .rstN        (rstN),
  .enable      (enable),
  .stopReq     (stopReq),
  .sclPullDown (sclPullDown),
  .waitHigh    (waitHigh),
  .riseStrobe  (riseStrobe),
  .fallStrobe  (fallStrobe)
);

// File: tb/tb_scl_clock_sync.sv
`timescale 1ns/1ps
module tb_scl_clock_sync;
  localparam int CNT_W = 8;

  typedef struct {
    int    len;
    string req;
  } expItem_t;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic [CNT_W-1:0] lowCount = '0;
  logic [CNT_W-1:0] highCount = '0;
  logic             enable = 1'b0;
  logic             stopReq = 1'b0;
  logic             sclBus;
  logic             sclPullDown, waitHigh, riseStrobe, fallStrobe;

  // other devices on the wired-AND line
  int   m2Len = 0;
  int   m2Cnt = 0;
  int   slvLen = 0;
  int   slvAt = -1;
  int   slvCnt = 0;
  int   periodIdx = 0;
  logic extPd = 1'b0;
  logic m2Pd, slvPd;

  int testsRun = 0;
  int testsFailed = 0;
  int cyc = 0;
  int armCycle = 0;
  bit armed = 0;

  expItem_t lowQ[$];
  expItem_t highQ[$];
  expItem_t waitQ[$];

  always #2 clk = ~clk;

  scl_clock_sync #(.CNT_W(CNT_W)) dut (
    .clk         (clk),
    .rstN        (rstN),
    .lowCount    (lowCount),
    .highCount   (highCount),
    .enable      (enable),
    .stopReq     (stopReq),
    .sclIn       (sclBus),
    .sclPullDown (sclPullDown),
    .waitHigh    (waitHigh),
    .riseStrobe  (riseStrobe),
    .fallStrobe  (fallStrobe)
  );

  assign m2Pd   = (fallStrobe && m2Len > 0) || (m2Cnt != 0);
  assign slvPd  = (fallStrobe && periodIdx == slvAt) || (slvCnt != 0);
  assign sclBus = !(sclPullDown || m2Pd || slvPd || extPd);

  always @(posedge clk) begin
    if (!enable) periodIdx <= 0;
    else if (fallStrobe) periodIdx <= periodIdx + 1;
    if (fallStrobe && m2Len > 1) m2Cnt <= m2Len - 1;
    else if (m2Cnt != 0) m2Cnt <= m2Cnt - 1;
    if (fallStrobe && periodIdx == slvAt && slvLen > 1) slvCnt <= slvLen - 1;
    else if (slvCnt != 0) slvCnt <= slvCnt - 1;
  end

  task automatic checkEq(string req, string what, int act, int exp);
    testsRun++;
    if (act != exp) begin
      testsFailed++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic pushRun(bit isLow, int len, string req);
    expItem_t it;
    it.len = len;
    it.req = req;
    if (isLow) lowQ.push_back(it);
    else highQ.push_back(it);
  endtask

  task automatic pushWait(int len, string req);
    expItem_t it;
    it.len = len;
    it.req = req;
    waitQ.push_back(it);
  endtask

  // monitor: measures line runs and wait episodes, pops expectations
  logic busLvl = 1'b1;
  int   runLen = 0;
  int   runStart = 0;
  logic waitLvl = 1'b0;
  int   waitLen = 0;
  int   waitStart = 0;

  always @(negedge clk) begin
    expItem_t it;
    cyc++;
    if (rstN) begin
      if (sclBus == busLvl) runLen++;
      else begin
        if (armed && runStart >= armCycle) begin
          if (!busLvl && lowQ.size() > 0) begin
            it = lowQ.pop_front();
            checkEq(it.req, "line low run", runLen, it.len);
          end else if (busLvl && highQ.size() > 0) begin
            it = highQ.pop_front();
            checkEq(it.req, "line high run", runLen, it.len);
          end
        end
        busLvl = sclBus;
        runLen = 1;
        runStart = cyc;
      end
      if (waitHigh == waitLvl) begin
        if (waitLvl) waitLen++;
      end else begin
        if (!waitHigh && armed && waitStart >= armCycle && waitQ.size() > 0) begin
          it = waitQ.pop_front();
          checkEq(it.req, "waitHigh length", waitLen, it.len);
        end
        waitLvl = waitHigh;
        waitLen = 1;
        waitStart = cyc;
      end
      if (riseStrobe && armed && runStart >= armCycle)
        checkEq("R8", "high-run position of riseStrobe", busLvl ? runLen : 0, 4);
      if (fallStrobe && armed)
        checkEq("R9", "pull-down with fallStrobe", int'(sclPullDown), 1);
    end
  end

  task automatic runScenario(int l, int h, bit doAbort);
    @(posedge clk); #1;
    lowCount  = CNT_W'(l);
    highCount = CNT_W'(h);
    armCycle  = cyc + 1;
    armed     = 1;
    enable    = 1'b1;
    stopReq   = 1'b0;
    if (doAbort) begin
      do @(negedge clk); while (!riseStrobe);
      @(posedge clk); #1 extPd = 1'b1;
      repeat (3) @(posedge clk);
      #1 extPd = 1'b0;
    end
    while (lowQ.size() > 0 || highQ.size() > 0 || waitQ.size() > 0) @(negedge clk);
    @(posedge clk); #1;
    enable = 1'b0;
    armed  = 0;
    repeat (30) @(posedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    testsFailed++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    checkEq("R1", "pull-down in reset", int'(sclPullDown), 0);
    checkEq("R1", "strobes in reset", int'(riseStrobe | fallStrobe | waitHigh), 0);
    @(posedge clk); #1 rstN = 1'b1;
    repeat (4) @(negedge clk);
    checkEq("R1", "pull-down idle", int'(sclPullDown), 0);
    checkEq("R1", "wait/strobes idle", int'(riseStrobe | fallStrobe | waitHigh), 0);

    // R2 R3 R5: lone master
    for (int i = 0; i < 3; i++) begin
      pushRun(1, 5, "R2");
      pushRun(0, 5, "R3");
      pushWait(3, "R5");
    end
    runScenario(5, 2, 0);

    // R2 R3: zero counts act as one
    for (int i = 0; i < 3; i++) begin
      pushRun(1, 1, "R2");
      pushRun(0, 4, "R3");
      pushWait(3, "R5");
    end
    runScenario(0, 0, 0);

    // R4: second master with longer low time
    m2Len = 7;
    for (int i = 0; i < 3; i++) begin
      pushRun(1, 7, "R4");
      pushRun(0, 8, "R4");
      pushWait(6, "R5");
    end
    runScenario(4, 5, 0);
    m2Len = 0;

    // R6: slave stretches period 1
    slvLen = 12;
    slvAt  = 1;
    pushRun(1, 3, "R6");  pushRun(0, 7, "R6");  pushWait(3, "R6");
    pushRun(1, 12, "R6"); pushRun(0, 7, "R6");  pushWait(12, "R6");
    pushRun(1, 3, "R6");  pushRun(0, 7, "R6");  pushWait(3, "R6");
    runScenario(3, 4, 0);
    slvAt = -1;

    // R7: falling edge during the high count
    pushRun(1, 4, "R7"); pushRun(0, 4, "R7");  pushWait(3, "R7");
    pushRun(1, 7, "R7"); pushRun(0, 13, "R7"); pushWait(3, "R7");
    pushRun(1, 4, "R7"); pushRun(0, 13, "R7"); pushWait(3, "R7");
    runScenario(4, 10, 1);

    // R10: stop during a low phase, line stays released
    @(posedge clk); #1;
    lowCount  = CNT_W'(20);
    highCount = CNT_W'(3);
    enable    = 1'b1;
    do @(negedge clk); while (!sclPullDown);
    @(posedge clk); #1 stopReq = 1'b1;
    @(posedge clk);
    @(negedge clk);
    checkEq("R10", "pull-down after stop", int'(sclPullDown), 0);
    repeat (10) @(negedge clk);
    checkEq("R10", "pull-down while stopped", int'(sclPullDown | waitHigh), 0);
    @(posedge clk); #1 stopReq = 1'b0;
    do @(negedge clk); while (!sclPullDown);
    @(posedge clk); #1 enable = 1'b0;
    @(posedge clk);
    @(negedge clk);
    checkEq("R10", "pull-down after disable", int'(sclPullDown | waitHigh), 0);

    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule